// File: doc/BRIEF.md
# Floating-Point Condition Code Unit

This block owns the 2-bit condition code of a hexadecimal floating-point execution unit. For every floating-point instruction it is shown, it checks the register fields and, for memory-operand forms, the operand address. It then either raises a one-cycle specification-interrupt request or, if the instruction class is one that sets the code, computes the new code. For arithmetic and load classes the code comes from the result word. For compare it comes from an exact ordering of the two operands. The arithmetic itself, normalization and the register file sit elsewhere. This block only sees their outputs and an overflow flag.

The instruction word is 16 bits. Its most significant byte is the opcode: the low nibble of the opcode is the class, and the next bit selects long (1) or short (0) operands. The next nibble down is the first register field, and the lowest nibble is the second register field. The condition code is held between updates. It is written only by add/subtract, compare, and the sign-control and test loads.

Top module: `fp_cc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `cc` becomes 0 and `spec_irq` becomes 0.
- R2: A valid instruction whose first register field (`instr_word[7:4]`) is not 0, 2, 4 or 6 is a specification fault. In register form (`mem_op`=0) the second register field (`instr_word[3:0]`) is checked the same way. In memory form the second field is ignored.
- R3: In memory form a long operand (`instr_word[12]`=1) needs `eff_addr[2:0]`=0 and a short operand needs `eff_addr[1:0]`=0; otherwise it is a specification fault. In register form `eff_addr` has no effect.
- R4: Classes 0 to 3 (add/subtract, normalized and unnormalized) give code 3 when `arith_ovf` is 1. Otherwise they give 0 for a zero result, 1 for a negative result and 2 for a positive result.
- R5: Class 4 (compare) gives 0 when the operands are equal, 1 when the first is lower and 2 when the first is higher; it never gives 3. Zero values of either sign and any exponent are equal, so identical operands give 0.
- R6: Compare orders nonzero values first by sign (negative is lower). For equal signs it orders them by exact magnitude fraction×16^exponent, which may need fraction alignment across exponents, and the magnitude order is reversed when both are negative.
- R7: Classes 5 (load and test) and 6 (load complement) give 0, 1 or 2 for a zero, negative or positive result and ignore `arith_ovf`.
- R8: Class 7 (load negative) gives 0 for a zero result and 1 otherwise. Class 8 (load positive) gives 0 for a zero result and 2 otherwise. In neither case does the result sign matter.
- R9: Classes 9 to 15, and cycles with `instr_valid` low, leave `cc` unchanged.
- R10: A valid instruction updates `cc` at the same rising edge where it is sampled. A faulted instruction leaves `cc` unchanged and sets `spec_irq` for exactly the following cycle.
- R11: A value is zero when its fraction is all zeros. A long value is sign bit 63, exponent bits 62:56 and fraction bits 55:0. A short value is sign bit 31, exponent bits 30:24 and fraction bits 23:0, and bits 63:32 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr_word | input | 16 | Opcode (15:8), first register field (7:4), second register field (3:0) |
| mem_op | input | 1 | Instruction uses a storage operand |
| eff_addr | input | ADDR_W | Effective storage address of the operand |
| result_val | input | 64 | Result from the arithmetic or load datapath |
| cmp_a | input | 64 | First compare operand |
| cmp_b | input | 64 | Second compare operand |
| arith_ovf | input | 1 | Exponent overflow from the arithmetic datapath |
| cc | output | 2 | Held condition code |
| spec_irq | output | 1 | Specification-interrupt request, one cycle |

## Verification
The assertions assume that `instr_valid` marks a single-cycle request and that the class and size bits sit in the low five opcode bits. They assume that `arith_ovf` is meaningful only for classes 0 to 3 and is ignored elsewhere. The stimulus drives all inputs on the falling edge, holds `instr_valid` for one cycle per instruction, and mixes in idle cycles. It deliberately raises `arith_ovf` on load classes to show that the flag is ignored there. Compare operands are drawn so that equal values with different exponents, signed zeros and exponent gaps beyond the fraction width all occur.

// File: rtl/fpcc_pkg.sv
// Package: shared class and condition-code encodings for the
// floating-point condition code unit.
// Assumes: class is the low opcode nibble; codes are 2 bits.
package fpcc_pkg;

    localparam logic [3:0] CL_ADD_N = 4'd0;
    localparam logic [3:0] CL_ADD_U = 4'd1;
    localparam logic [3:0] CL_SUB_N = 4'd2;
    localparam logic [3:0] CL_SUB_U = 4'd3;
    localparam logic [3:0] CL_CMP   = 4'd4;
    localparam logic [3:0] CL_LTEST = 4'd5;
    localparam logic [3:0] CL_LCOMP = 4'd6;
    localparam logic [3:0] CL_LNEG  = 4'd7;
    localparam logic [3:0] CL_LPOS  = 4'd8;

    localparam logic [1:0] CC_ZERO = 2'd0;
    localparam logic [1:0] CC_LOW  = 2'd1;
    localparam logic [1:0] CC_HIGH = 2'd2;
    localparam logic [1:0] CC_OVF  = 2'd3;

endpackage

// File: rtl/fpcc_unpack.sv
// Module: fpcc_unpack
// Splits a raw operand word into sign, exponent and a left-justified
// long fraction, and flags zero (all-zero fraction).
// Assumes: short operands live in the low SH_W bits of the raw word.
module fpcc_unpack #(
    parameter int EXP_W   = 7,
    parameter int LFRAC_W = 56,
    parameter int SFRAC_W = 24,
    localparam int OP_W   = 1 + EXP_W + LFRAC_W,
    localparam int SH_W   = 1 + EXP_W + SFRAC_W,
    localparam int PAD_W  = LFRAC_W - SFRAC_W
) (
    input  logic [OP_W-1:0]    raw,
    input  logic               is_long,
    output logic               sign,
    output logic [EXP_W-1:0]   expo,
    output logic [LFRAC_W-1:0] frac,
    output logic               is_zero
);

    logic unused_short_hi;
    assign unused_short_hi = ^raw[OP_W-1:SH_W];

    // Field select by operand size.
    always_comb begin
        if (is_long) begin
            sign = raw[OP_W-1];
            expo = raw[OP_W-2 -: EXP_W];
            frac = raw[LFRAC_W-1:0];
        end else begin
            sign = raw[SH_W-1];
            expo = raw[SH_W-2 -: EXP_W];
            frac = {raw[SFRAC_W-1:0], {PAD_W{1'b0}}};
        end
        is_zero = (frac == '0);
    end

endmodule

// File: rtl/fpcc_mag_cmp.sv
// Module: fpcc_mag_cmp
// Exact magnitude ordering of two nonzero values frac*16^exp.
// Assumes: both fractions are nonzero (zeros are handled upstream).
// The larger-exponent fraction is shifted left by whole hex digits
// into a double-width field; a gap of a full fraction width or more
// decides the order directly.
module fpcc_mag_cmp #(
    parameter int EXP_W   = 7,
    parameter int LFRAC_W = 56,
    localparam int DIG    = LFRAC_W / 4,
    localparam int WIDE   = 2 * LFRAC_W
) (
    input  logic [EXP_W-1:0]   exp_a,
    input  logic [LFRAC_W-1:0] frac_a,
    input  logic [EXP_W-1:0]   exp_b,
    input  logic [LFRAC_W-1:0] frac_b,
    output logic               a_gt,
    output logic               a_lt
);

    logic               a_big;
    logic [EXP_W-1:0]   gap;
    logic [LFRAC_W-1:0] big_f, small_f;
    logic [WIDE-1:0]    big_sh, small_ext;
    logic               big_gt, small_gt;

    // Pick the operand with the larger exponent and the digit gap.
    always_comb begin
        a_big   = (exp_a >= exp_b);
        gap     = a_big ? (exp_a - exp_b) : (exp_b - exp_a);
        big_f   = a_big ? frac_a : frac_b;
        small_f = a_big ? frac_b : frac_a;
    end

    // Align by shifting the larger-exponent fraction left and compare.
    always_comb begin
        small_ext = {{(WIDE-LFRAC_W){1'b0}}, small_f};
        big_sh    = '0;
        if (int'(gap) >= DIG) begin
            big_gt   = 1'b1;
            small_gt = 1'b0;
        end else begin
            big_sh   = {{(WIDE-LFRAC_W){1'b0}}, big_f} << {gap, 2'b00};
            big_gt   = (big_sh > small_ext);
            small_gt = (small_ext > big_sh);
        end
    end

    // Map back to operand order.
    always_comb begin
        a_gt = a_big ? big_gt : small_gt;
        a_lt = a_big ? small_gt : big_gt;
    end

endmodule

// File: rtl/fpcc_compare.sv
// Module: fpcc_compare
// Orders two unpacked floating-point values and yields a compare code:
// 0 equal, 1 first lower, 2 first higher.
// Assumes: zero is flagged by the unpacker; signed zeros are equal.
module fpcc_compare #(
    parameter int EXP_W   = 7,
    parameter int LFRAC_W = 56
) (
    input  logic               sign_a,
    input  logic [EXP_W-1:0]   exp_a,
    input  logic [LFRAC_W-1:0] frac_a,
    input  logic               zero_a,
    input  logic               sign_b,
    input  logic [EXP_W-1:0]   exp_b,
    input  logic [LFRAC_W-1:0] frac_b,
    input  logic               zero_b,
    output logic [1:0]         cmp_code
);
    import fpcc_pkg::*;

    logic mag_gt, mag_lt;
    logic first_gt, first_lt;

    fpcc_mag_cmp #(.EXP_W(EXP_W), .LFRAC_W(LFRAC_W)) u_mag (
        .exp_a (exp_a),
        .frac_a(frac_a),
        .exp_b (exp_b),
        .frac_b(frac_b),
        .a_gt  (mag_gt),
        .a_lt  (mag_lt)
    );

    // Resolve zero, sign and magnitude precedence.
    always_comb begin
        first_gt = 1'b0;
        first_lt = 1'b0;
        if (zero_a && zero_b) begin
            first_gt = 1'b0;
        end else if (zero_a) begin
            first_gt = sign_b;
            first_lt = !sign_b;
        end else if (zero_b) begin
            first_gt = !sign_a;
            first_lt = sign_a;
        end else if (sign_a != sign_b) begin
            first_gt = sign_b;
            first_lt = sign_a;
        end else if (sign_a) begin
            first_gt = mag_lt;
            first_lt = mag_gt;
        end else begin
            first_gt = mag_gt;
            first_lt = mag_lt;
        end
    end

    // Encode the ordering.
    always_comb begin
        if (first_gt)      cmp_code = CC_HIGH;
        else if (first_lt) cmp_code = CC_LOW;
        else               cmp_code = CC_ZERO;
    end

endmodule

// File: rtl/fpcc_spec_check.sv
// Module: fpcc_spec_check
// Detects specification faults: register fields outside {0,2,4,6}
// and storage operands not aligned to their size.
// Assumes: second field names a register only in register form.
module fpcc_spec_check #(
    parameter int ADDR_W   = 24,
    parameter int SHORT_AL = 2,
    parameter int LONG_AL  = 3
) (
    input  logic [3:0]        fld_first,
    input  logic [3:0]        fld_second,
    input  logic              mem_op,
    input  logic              is_long,
    input  logic [ADDR_W-1:0] addr,
    output logic              fault
);

    logic [1:0] fld_bad;
    logic [1:0] fld_used;
    logic       mis_short, mis_long, misaligned;

    assign fld_used = {!mem_op, 1'b1};

    // One legality checker per register field.
    for (genvar g = 0; g < 2; g++) begin : g_fld
        logic [3:0] f;
        assign f = (g == 0) ? fld_first : fld_second;
        assign fld_bad[g] = fld_used[g] && (f[0] || f[3]);
    end

    // Alignment against the operand size.
    always_comb begin
        mis_short  = (addr[SHORT_AL-1:0] != '0);
        mis_long   = (addr[LONG_AL-1:0] != '0);
        misaligned = mem_op && (is_long ? mis_long : mis_short);
    end

    logic unused_addr_hi;
    assign unused_addr_hi = ^addr[ADDR_W-1:LONG_AL];

    assign fault = (|fld_bad) || misaligned;

endmodule

// File: rtl/fpcc_cc_select.sv
// Module: fpcc_cc_select
// Chooses the next condition code per instruction class and says
// whether the class writes the code at all.
// Assumes: result sign/zero and compare code are already decoded.
module fpcc_cc_select (
    input  logic [3:0] op_class,
    input  logic       ovf,
    input  logic       res_sign,
    input  logic       res_zero,
    input  logic [1:0] cmp_code,
    output logic [1:0] next_cc,
    output logic       writes
);
    import fpcc_pkg::*;

    logic [1:0] signed_code;

    // Three-way code from the result value.
    always_comb begin
        if (res_zero)      signed_code = CC_ZERO;
        else if (res_sign) signed_code = CC_LOW;
        else               signed_code = CC_HIGH;
    end

    // Class-specific selection.
    always_comb begin
        writes  = 1'b1;
        next_cc = CC_ZERO;
        case (op_class)
            CL_ADD_N, CL_ADD_U, CL_SUB_N, CL_SUB_U:
                next_cc = ovf ? CC_OVF : signed_code;
            CL_CMP:
                next_cc = cmp_code;
            CL_LTEST, CL_LCOMP:
                next_cc = signed_code;
            CL_LNEG:
                next_cc = res_zero ? CC_ZERO : CC_LOW;
            CL_LPOS:
                next_cc = res_zero ? CC_ZERO : CC_HIGH;
            default: begin
                writes  = 1'b0;
                next_cc = CC_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/fp_cc_unit.sv
// Module: fp_cc_unit (top)
// Holds the floating-point condition code, checks each instruction's
// operand specification and updates the code per instruction class.
// Assumes: instr_valid is a one-cycle request; operands are stable
// while it is high; reset is synchronous and active low.
module fp_cc_unit #(
    parameter int ADDR_W  = 24,
    parameter int EXP_W   = 7,
    parameter int LFRAC_W = 56,
    parameter int SFRAC_W = 24,
    localparam int OP_W   = 1 + EXP_W + LFRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    input  logic              mem_op,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [OP_W-1:0]   result_val,
    input  logic [OP_W-1:0]   cmp_a,
    input  logic [OP_W-1:0]   cmp_b,
    input  logic              arith_ovf,
    output logic [1:0]        cc,
    output logic              spec_irq
);

    localparam int N_OPND = 3;

    logic [3:0] op_class;
    logic       is_long;
    logic       fault;
    logic [1:0] cmp_code, next_cc;
    logic       writes;

    logic [OP_W-1:0]    raw   [N_OPND];
    logic               sgn   [N_OPND];
    logic [EXP_W-1:0]   ex    [N_OPND];
    logic [LFRAC_W-1:0] fr    [N_OPND];
    logic               zr    [N_OPND];

    logic unused_opc_hi;
    assign unused_opc_hi = ^instr_word[15:13];

    assign op_class = instr_word[11:8];
    assign is_long  = instr_word[12];

    assign raw[0] = result_val;
    assign raw[1] = cmp_a;
    assign raw[2] = cmp_b;

    // One unpacker per operand word.
    for (genvar i = 0; i < N_OPND; i++) begin : g_unp
        fpcc_unpack #(.EXP_W(EXP_W), .LFRAC_W(LFRAC_W), .SFRAC_W(SFRAC_W)) u_unp (
            .raw    (raw[i]),
            .is_long(is_long),
            .sign   (sgn[i]),
            .expo   (ex[i]),
            .frac   (fr[i]),
            .is_zero(zr[i])
        );
    end

    logic unused_res_exp;
    assign unused_res_exp = ^{ex[0], fr[0]};

    fpcc_spec_check #(.ADDR_W(ADDR_W)) u_spec (
        .fld_first (instr_word[7:4]),
        .fld_second(instr_word[3:0]),
        .mem_op    (mem_op),
        .is_long   (is_long),
        .addr      (eff_addr),
        .fault     (fault)
    );

    fpcc_compare #(.EXP_W(EXP_W), .LFRAC_W(LFRAC_W)) u_cmp (
        .sign_a  (sgn[1]),
        .exp_a   (ex[1]),
        .frac_a  (fr[1]),
        .zero_a  (zr[1]),
        .sign_b  (sgn[2]),
        .exp_b   (ex[2]),
        .frac_b  (fr[2]),
        .zero_b  (zr[2]),
        .cmp_code(cmp_code)
    );

    fpcc_cc_select u_sel (
        .op_class(op_class),
        .ovf     (arith_ovf),
        .res_sign(sgn[0]),
        .res_zero(zr[0]),
        .cmp_code(cmp_code),
        .next_cc (next_cc),
        .writes  (writes)
    );

    // Condition code register and interrupt request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc       <= 2'd0;
            spec_irq <= 1'b0;
        end else begin
            spec_irq <= instr_valid && fault;
            if (instr_valid && !fault && writes)
                cc <= next_cc;
        end
    end

endmodule

// File: rtl/fpcc_checker.sv
// Module: fpcc_checker
// Temporal properties of fp_cc_unit, observed at its ports only.
// Assumes: instr_valid is a one-cycle request per instruction.
module fpcc_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [15:0]       instr_word,
    input logic              mem_op,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              arith_ovf,
    input logic [1:0]        cc,
    input logic              spec_irq
);

    logic [3:0] cls;
    assign cls = instr_word[11:8];

    logic unused_chk;
    assign unused_chk = ^{instr_word[15:12], instr_word[6:5], instr_word[3:0], eff_addr};

    p_bad_first_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (instr_word[4] || instr_word[7]) |=> spec_irq);

    p_misaligned_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && mem_op && (eff_addr[1:0] != 2'b00) |=> spec_irq);

    p_ovf_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (cls <= 4'd3) && arith_ovf |=> spec_irq || (cc == 2'd3));

    p_no_cc3_compare_r5: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (cls == 4'd4) |=> spec_irq || (cc != 2'd3));

    p_no_cc3_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && ((cls == 4'd5) || (cls == 4'd6)) |=> spec_irq || (cc != 2'd3));

    p_lneg_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (cls == 4'd7) |=> spec_irq || (cc <= 2'd1));

    p_lpos_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (cls == 4'd8) |=> spec_irq || (cc == 2'd0) || (cc == 2'd2));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(cc));

    p_other_class_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (cls >= 4'd9) |=> $stable(cc));

    p_fault_keeps_cc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spec_irq |-> (cc == $past(cc)));

    p_irq_needs_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spec_irq |-> $past(instr_valid));

endmodule

bind fp_cc_unit fpcc_checker #(.ADDR_W(ADDR_W)) u_fpcc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .instr_word (instr_word),
    .mem_op     (mem_op),
    .eff_addr   (eff_addr),
    .arith_ovf  (arith_ovf),
    .cc         (cc),
    .spec_irq   (spec_irq)
);

// File: tb/test_fp_cc_unit.sv
// Bench for fp_cc_unit: behavioural reference model updated on each
// rising edge, compared with the design on every falling edge.
module test_fp_cc_unit;

    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              instr_valid = 1'b0;
    logic [15:0]       instr_word = '0;
    logic              mem_op = 1'b0;
    logic [ADDR_W-1:0] eff_addr = '0;
    logic [63:0]       result_val = '0;
    logic [63:0]       cmp_a = '0;
    logic [63:0]       cmp_b = '0;
    logic              arith_ovf = 1'b0;
    logic [1:0]        cc;
    logic              spec_irq;

    int    checks = 0;
    int    errors = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R9";

    int    m_cc = 0;
    int    m_irq = 0;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    fp_cc_unit #(.ADDR_W(ADDR_W)) i_fp_cc_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .mem_op(mem_op), .eff_addr(eff_addr),
        .result_val(result_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .arith_ovf(arith_ovf), .cc(cc), .spec_irq(spec_irq)
    );

    // ---------------- reference model ----------------
    function automatic void unpk(input logic [63:0] v, input bit lng,
                                 output bit s, output int e, output logic [55:0] f);
        if (lng) begin s = v[63]; e = int'(v[62:56]); f = v[55:0]; end
        else     begin s = v[31]; e = int'(v[30:24]); f = {v[23:0], 32'h0}; end
    endfunction

    function automatic int ref_cmp(input logic [63:0] a, input logic [63:0] b, input bit lng);
        bit sa, sb; int ea, eb; logic [55:0] fa, fb; int mag;
        unpk(a, lng, sa, ea, fa);
        unpk(b, lng, sb, eb, fb);
        if (fa == 0 && fb == 0) return 0;
        if (fa == 0) return sb ? 2 : 1;
        if (fb == 0) return sa ? 1 : 2;
        if (sa != sb) return sa ? 1 : 2;
        while (fa[55:52] == 4'h0) begin fa = fa << 4; ea--; end
        while (fb[55:52] == 4'h0) begin fb = fb << 4; eb--; end
        if (ea != eb) mag = (ea > eb) ? 1 : -1;
        else if (fa != fb) mag = (fa > fb) ? 1 : -1;
        else mag = 0;
        if (sa) mag = -mag;
        return (mag == 0) ? 0 : ((mag > 0) ? 2 : 1);
    endfunction

    function automatic bit ref_fault(input logic [15:0] w, input bit mem, input logic [ADDR_W-1:0] ad);
        int r1 = int'(w[7:4]);
        int r2 = int'(w[3:0]);
        bit bad = !(r1 == 0 || r1 == 2 || r1 == 4 || r1 == 6);
        if (!mem && !(r2 == 0 || r2 == 2 || r2 == 4 || r2 == 6)) bad = 1;
        if (mem && (w[12] ? (ad % 8 != 0) : (ad % 4 != 0))) bad = 1;
        return bad;
    endfunction

    always @(posedge clk) begin
        bit s; int e; logic [55:0] f; int cls; int nc; bit lng;
        if (!rst_n) begin
            m_cc  <= 0; m_irq <= 0; m_tag <= "R1";
        end else if (!instr_valid) begin
            m_irq <= 0; m_tag <= "R9";
        end else if (ref_fault(instr_word, mem_op, eff_addr)) begin
            m_irq <= 1; m_tag <= cur_tag;
        end else begin
            m_irq <= 0; m_tag <= cur_tag;
            cls = int'(instr_word[11:8]);
            lng = instr_word[12];
            unpk(result_val, lng, s, e, f);
            nc = m_cc;
            if (cls <= 3) nc = arith_ovf ? 3 : (f == 0 ? 0 : (s ? 1 : 2));
            else if (cls == 4) nc = ref_cmp(cmp_a, cmp_b, lng);
            else if (cls == 5 || cls == 6) nc = (f == 0) ? 0 : (s ? 1 : 2);
            else if (cls == 7) nc = (f == 0) ? 0 : 1;
            else if (cls == 8) nc = (f == 0) ? 0 : 2;
            m_cc <= nc;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            checks++;
            if (int'(cc) != m_cc) begin
                errors++;
                $display("FAIL %s cc actual=%0d expected=%0d", m_tag, cc, m_cc);
            end
            checks++;
            if (int'(spec_irq) != m_irq) begin
                errors++;
                $display("FAIL %s spec_irq actual=%0d expected=%0d", m_tag, spec_irq, m_irq);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [63:0] mk(input bit lng, input bit s, input int e, input logic [55:0] f);
        if (lng) return {s, e[6:0], f};
        return {32'h0, s, e[6:0], f[23:0]};
    endfunction

    function automatic string auto_tag(input int cls);
        if (cls <= 3) return "R4";
        if (cls == 4) return "R5";
        if (cls == 5 || cls == 6) return "R7";
        if (cls == 7 || cls == 8) return "R8";
        return "R9";
    endfunction

    task automatic issue(input int cls, input bit lng, input int r1, input int r2,
                         input bit mem, input int addr, input logic [63:0] res,
                         input logic [63:0] a, input logic [63:0] b, input bit ovf,
                         input string tag);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = {3'b000, lng, cls[3:0], r1[3:0], r2[3:0]};
        mem_op      = mem;
        eff_addr    = addr[ADDR_W-1:0];
        result_val  = res;
        cmp_a       = a;
        cmp_b       = b;
        arith_ovf   = ovf;
        cur_tag     = (tag == "") ? auto_tag(cls) : tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            instr_valid = 1'b0;
            cur_tag = "R9";
        end
    endtask

    function automatic logic [63:0] rand_op(input bit lng);
        logic [55:0] f = {$urandom, $urandom};
        int sel = int'($urandom % 4);
        if (sel == 0) f = '0;
        if (sel == 1) f = f >> (4 * ($urandom % 12));
        return mk(lng, 1'($urandom), 60 + int'($urandom % 8), f);
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- tests ----------------
    initial begin
        logic [63:0] a, b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (cc !== 2'd0 || spec_irq !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset cc=%0d irq=%0d expected 0 0", cc, spec_irq);
        end
        rst_n = 1'b1;
        chk_en = 1'b1;

        // R4 add/subtract
        issue(0, 1, 0, 2, 0, 0, mk(1, 0, 65, 56'h1), 0, 0, 0, "R4");
        issue(1, 1, 2, 4, 0, 0, mk(1, 1, 65, 56'h10), 0, 0, 0, "R4");
        issue(2, 0, 4, 6, 0, 0, mk(0, 1, 3, 56'h0), 0, 0, 0, "R4");
        issue(3, 0, 6, 0, 0, 0, mk(0, 0, 3, 56'h0), 0, 0, 1, "R4");
        idle(2);
        // R5 compare
        a = mk(1, 0, 66, 56'h123456);
        issue(4, 1, 2, 2, 0, 0, 0, a, a, 0, "R5");
        issue(4, 1, 0, 2, 0, 0, 0, mk(1, 1, 5, 0), mk(1, 0, 90, 0), 0, "R5");
        issue(4, 0, 0, 2, 0, 0, 0, mk(0, 0, 64, 56'h1), mk(0, 0, 64, 56'h2), 0, "R5");
        issue(4, 0, 0, 2, 0, 0, 0, mk(0, 0, 64, 0), mk(0, 1, 64, 56'h5), 0, "R5");
        // R6 ordering with alignment
        issue(4, 1, 0, 2, 0, 0, 0, mk(1, 0, 65, 56'h10_0000), mk(1, 0, 66, 56'h1_0000), 0, "R6");
        issue(4, 1, 0, 2, 0, 0, 0, mk(1, 1, 70, 56'h1), mk(1, 1, 64, 56'hFF_FFFF_FFFF), 0, "R6");
        issue(4, 1, 0, 2, 0, 0, 0, mk(1, 0, 100, 56'h1), mk(1, 0, 64, 56'hFF_FFFF_FFFF_FFFF), 0, "R6");
        issue(4, 0, 0, 2, 0, 0, 0, mk(0, 1, 64, 56'h1), mk(0, 0, 10, 56'h1), 0, "R6");
        // R7 test/complement ignore overflow
        issue(5, 1, 0, 0, 0, 0, mk(1, 1, 64, 56'h9), 0, 0, 1, "R7");
        issue(6, 1, 0, 0, 0, 0, mk(1, 0, 64, 56'h9), 0, 0, 1, "R7");
        // R8 sign-control loads
        issue(7, 1, 0, 0, 0, 0, mk(1, 0, 64, 56'h7), 0, 0, 0, "R8");
        issue(8, 1, 0, 0, 0, 0, mk(1, 1, 64, 56'h7), 0, 0, 0, "R8");
        issue(7, 1, 0, 0, 0, 0, mk(1, 1, 64, 56'h0), 0, 0, 0, "R8");
        issue(8, 1, 0, 0, 0, 0, mk(1, 1, 64, 56'h7), 0, 0, 0, "R8");
        // R9 non-setting classes keep code 2
        issue(9, 1, 0, 0, 0, 0, mk(1, 1, 64, 56'h7), 0, 0, 1, "R9");
        issue(15, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
        idle(3);
        // R2 register fields
        issue(0, 1, 3, 0, 0, 0, mk(1, 1, 64, 56'h7), 0, 0, 0, "R2");
        issue(0, 1, 0, 8, 0, 0, mk(1, 1, 64, 56'h7), 0, 0, 0, "R2");
        issue(0, 1, 2, 5, 1, 16, mk(1, 1, 64, 56'h7), 0, 0, 0, "R2");
        // R3 alignment
        issue(0, 1, 0, 0, 1, 4, mk(1, 0, 64, 56'h7), 0, 0, 0, "R3");
        issue(0, 0, 0, 0, 1, 4, mk(0, 0, 64, 56'h7), 0, 0, 0, "R3");
        issue(0, 0, 0, 0, 1, 6, mk(0, 1, 64, 56'h7), 0, 0, 0, "R3");
        issue(1, 0, 0, 0, 0, 3, mk(0, 0, 64, 56'h0), 0, 0, 0, "R3");
        // R10 fault keeps code, irq one cycle
        issue(3, 1, 1, 0, 0, 0, mk(1, 1, 64, 56'h7), 0, 0, 1, "R10");
        idle(2);
        // R11 short ignores upper bits
        issue(5, 0, 0, 0, 0, 0, {32'hFFFF_FFFF, 32'h4100_0000}, 0, 0, 0, "R11");
        issue(4, 0, 0, 2, 0, 0, 0, {32'h1234_5678, 32'h4110_0000},
              {32'h0, 32'h4220_0000}, 0, "R11");
        idle(1);

        // Random mix
        for (int k = 0; k < 600; k++) begin
            bit lng = 1'($urandom);
            int cls = int'($urandom % 16);
            int r1 = ($urandom % 8 == 0) ? int'($urandom % 16) : 2 * int'($urandom % 4);
            int r2 = ($urandom % 8 == 0) ? int'($urandom % 16) : 2 * int'($urandom % 4);
            bit mem = ($urandom % 4 == 0);
            int ad = int'($urandom % 64);
            int pick = int'($urandom % 3);
            a = rand_op(lng);
            b = rand_op(lng);
            if (pick == 0) b = a;
            if (pick == 1 && lng) b = {a[63], a[62:56] + 7'd1, 4'h0, a[55:8], 4'h0};
            if (pick == 1 && !lng) b = {32'h0, a[31], a[30:24] + 7'd1, 4'h0, a[23:8], 4'h0};
            issue(cls, lng, r1, r2, mem, ad, rand_op(lng), a, b, ($urandom % 4 == 0), "");
            if ($urandom % 5 == 0) idle(1);
        end
        idle(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule